// File: doc/BRIEF.md
# Symmetric Bit-Serial FIR Filter

This block is a 16-tap FIR filter for signed 8-bit samples whose coefficient set is mirror-symmetric. Only eight distinct coefficients exist, so the filter first adds each sample to its mirror partner, forming eight 9-bit pair sums. It then weights and sums those pairs with distributed arithmetic rather than multipliers. Each clock, one bit position is taken from all eight pair sums and used as the address of a 256-entry table of coefficient partial sums. The table output goes to a shift-accumulator.

A sample is offered with a valid strobe. It is taken only while the block is idle. Nine cycles of bit-serial work follow, and then the 10-bit result appears with a one-cycle strobe. The coefficients, the output scaling shift and the overflow policy (clamp or wrap) are fixed when the block is elaborated. The partial-sum table is computed from the coefficient parameter.

Top module: `sym_da_fir`

## Requirements
- R1: While `rst_n` is low, `busy`, `out_valid` and `out_data` are 0. Every tap of the delay line is cleared, so the next results treat earlier samples as zero.
- R2: Let x[j] be the two's-complement sample accepted j acceptances before the newest one (x[0] is the newest). The full-precision result is the sum over k = 0..7 of c_k·(x[k] + x[15−k]). The coefficient c_k is the signed 8-bit field COEFS[8k+7:8k].
- R3: `in_data` is accepted on a rising clock edge where `in_valid` is 1 and `busy` is 0. `busy` is 1 for the 9 cycles that follow that edge, and is 0 otherwise.
- R4: A sample presented while `busy` is 1 is ignored. It does not enter the delay line and has no effect on any later result.
- R5: `out_valid` is 1 for exactly one cycle. That cycle begins at the 9th rising edge after the accepting edge, which is the same edge at which `busy` returns to 0.
- R6: Before the result is limited to 10 bits, the full-precision sum is shifted right arithmetically by OUT_SHIFT bits, rounding toward minus infinity.
- R7: With SATURATE = 1, the shifted value is clamped to the range −512..511 and is output in two's complement.
- R8: With SATURATE = 0, `out_data` is the low 10 bits of the shifted value.
- R9: `out_data` keeps its value in every cycle in which `out_valid` is 0.
- R10: A new sample can be accepted at the edge that ends the `out_valid` cycle, so the block can take one sample every 10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered this cycle |
| in_data | input | 8 | Signed input sample |
| busy | output | 1 | Bit-serial conversion in progress; input is ignored |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 10 | Signed filter result |

## Verification
The bench builds two instances with the default coefficient set {1, −2, 3, 5, −7, 11, 13, 17}, and both are driven from the same inputs. The first instance uses the defaults SATURATE = 1 and OUT_SHIFT = 4. Runs of full-scale samples drive it past both clamp limits. The second instance uses SATURATE = 0 and OUT_SHIFT = 2. With it, the same runs wrap around, and the low result bits, which a larger shift would discard, are checked directly. An impulse traces each coefficient through both mirrored taps. Continuous offering while the block is busy exercises the drop rule and back-to-back acceptance.

// File: rtl/sym_da_fir.sv
module sym_da_fir #(
  parameter int DW = 8,
  parameter int TAPS = 16,
  parameter int CW = 8,
  parameter int OW = 10,
  parameter int OUT_SHIFT = 4,
  parameter bit SATURATE = 1'b1,
  parameter logic [CW*(TAPS/2)-1:0] COEFS =
    {8'd17, 8'd13, 8'd11, 8'hF9, 8'd5, 8'd3, 8'hFE, 8'd1}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          busy,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  localparam int HALF = TAPS / 2;
  localparam int PW   = DW + 1;
  localparam int LW   = CW + $clog2(HALF);
  localparam int AW   = LW + PW + 1;
  localparam int BW   = $clog2(PW);
  localparam int NLUT = 2 ** HALF;
  localparam logic signed [AW-1:0] OMAX = AW'((1 << (OW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = ~OMAX;

  function automatic logic signed [LW-1:0] part_sum(int addr);
    int s;
    s = 0;
    for (int k = 0; k < HALF; k++)
      if (addr[k]) s += int'($signed(COEFS[k*CW +: CW]));
    return LW'(s);
  endfunction

  logic signed [DW-1:0] tap [TAPS];
  logic signed [PW-1:0] pair [HALF];
  logic [HALF-1:0]      slice;
  logic signed [LW-1:0] lut [NLUT];
  logic signed [LW-1:0] term;
  logic signed [AW-1:0] term_x, acc, acc_nxt, scaled;
  logic [BW-1:0]        bitc;
  logic [OW-1:0]        res;

  for (genvar a = 0; a < NLUT; a++) begin : g_lut
    assign lut[a] = part_sum(a);
  end

  for (genvar k = 0; k < HALF; k++) begin : g_pre
    assign pair[k]  = {tap[k][DW-1], tap[k]} + {tap[TAPS-1-k][DW-1], tap[TAPS-1-k]};
    assign slice[k] = pair[k][bitc];
  end

  assign term    = lut[slice];
  assign term_x  = {{(AW-LW){term[LW-1]}}, term};
  assign acc_nxt = (bitc == BW'(PW - 1)) ? (acc <<< 1) - term_x : (acc <<< 1) + term_x;
  assign scaled  = acc_nxt >>> OUT_SHIFT;

  if (SATURATE) begin : g_sat
    always_comb begin
      if (scaled > OMAX)      res = OMAX[OW-1:0];
      else if (scaled < OMIN) res = OMIN[OW-1:0];
      else                    res = scaled[OW-1:0];
    end
  end else begin : g_wrap
    assign res = scaled[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) tap[i] <= '0;
      busy      <= 1'b0;
      bitc      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          for (int i = TAPS - 1; i > 0; i--) tap[i] <= tap[i-1];
          tap[0] <= in_data;
          busy   <= 1'b1;
          bitc   <= BW'(PW - 1);
          acc    <= '0;
        end
      end else begin
        acc <= acc_nxt;
        if (bitc == '0) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= res;
        end else begin
          bitc <= bitc - 1'b1;
        end
      end
    end
  end

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  // R4
  hold_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tap[0]));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/sym_da_fir_test.sv
module sym_da_fir_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       busy, out_valid, busy_w, out_valid_w;
  logic [9:0] out_data, out_data_w;

  int checks = 0;
  int errors = 0;
  int dropped = 0;

  always #5 clk = ~clk;

  sym_da_fir uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );

  sym_da_fir #(.SATURATE(1'b0), .OUT_SHIFT(2)) uut_wrap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .busy(busy_w), .out_valid(out_valid_w), .out_data(out_data_w)
  );

  int cf [8] = '{1, -2, 3, 5, -7, 11, 13, 17};
  int hist [16];
  int m_cnt, m_valid, m_sat, m_wrap;

  function automatic int ref_out(int sh, bit sat);
    int full, sc, v;
    full = 0;
    for (int k = 0; k < 8; k++) full += cf[k] * (hist[k] + hist[15-k]);
    sc = full >>> sh;
    if (sat) begin
      if (sc > 511) sc = 511;
      if (sc < -512) sc = -512;
      return sc;
    end
    v = sc & 1023;
    if (v > 511) v -= 1024;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) hist[i] = 0;
      m_cnt = 0; m_valid = 0; m_sat = 0; m_wrap = 0;
    end else if (m_cnt == 0) begin
      m_valid = 0;
      if (in_valid) begin
        for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'($signed(in_data));
        m_cnt = 9;
      end
    end else begin
      if (in_valid) dropped++;
      m_cnt--;
      m_valid = 0;
      if (m_cnt == 0) begin
        m_valid = 1;
        m_sat  = ref_out(4, 1'b1);
        m_wrap = ref_out(2, 1'b0);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 R10 busy", int'(busy), int'(m_cnt > 0));
      check("R5 out_valid", int'(out_valid), m_valid);
      check("R3 R10 busy_wrap", int'(busy_w), int'(m_cnt > 0));
      check("R5 out_valid_wrap", int'(out_valid_w), m_valid);
      if (m_valid != 0) begin
        check("R2 R4 R6 R7 sat result", int'($signed(out_data)), m_sat);
        check("R2 R4 R6 R8 wrap result", int'($signed(out_data_w)), m_wrap);
      end else begin
        check("R9 sat hold", int'($signed(out_data)), m_sat);
        check("R9 wrap hold", int'($signed(out_data_w)), m_wrap);
      end
    end
  end

  task automatic put(bit v, int d);
    @(negedge clk);
    in_valid = v;
    in_data  = d[7:0];
  endtask

  task automatic feed(int d);
    put(1'b1, d);
    repeat (9) put(1'b0, 0);
  endtask

  task automatic check_reset();
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_data", int'(out_data), 0);
    check("R1 out_data_wrap", int'(out_data_w), 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    check_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R2: impulse walks through every tap
    feed(1);
    for (int i = 0; i < 16; i++) feed(0);
    // R7 R8: full-scale runs
    for (int i = 0; i < 16; i++) feed(-128);
    for (int i = 0; i < 16; i++) feed(127);
    for (int i = 0; i < 16; i++) feed((i % 2 == 0) ? 127 : -128);
    // R4 R10: offer every cycle while busy
    for (int i = 0; i < 300; i++) put(1'b1, i * 37);
    put(1'b0, 0);
    // R1: mid-run reset clears history
    repeat (3) put(1'b0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    feed(5);
    for (int i = 0; i < 16; i++) feed(0);
    // R2 R6: pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      put(lfsr[0] | lfsr[3], int'(lfsr[11:4]));
    end
    repeat (12) put(1'b0, 0);
    checks++;
    if (dropped == 0) begin
      errors++;
      $display("FAIL R4 dropped actual=0 expected=nonzero");
    end
    summary();
  end

endmodule